// File: doc/BRIEF.md
# Time-Alarm Comparator with Aligned Interval Pulse Generators

This block watches a free-running 64-bit nanosecond time value, supplied by a neighbouring timer, and compares it with two programmable alarm times. When the running time reaches an armed alarm, the block raises a one-cycle event flag and drives a matching alarm pin whose idle level is programmable. The time value advances by a tick period on every enabled clock. That step can exceed 1 ns, so a match is accepted anywhere inside the one-tick window that starts at the alarm value.

The first alarm can also act as the launch trigger for three interval pulse generators. Software sets the start-mode bit and then programs alarm 1 one tick before a chosen boundary, such as the next whole second. The generators wait for that alarm. Their first pulse falls on the boundary, and each later pulse follows one programmed period after the one before. If alarm 1 fires again while the generators run, it re-aligns their phase, unless a disable bit blocks this. A prescaler derives a divided output clock from the enabled cycles.

The generators share one controller with three states. In GS_IDLE they are stopped. In GS_WAIT they are armed and wait for alarm 1. In GS_RUN they are pulsing. The transitions are: *arm* (GS_IDLE to GS_WAIT when the start-mode bit is set); *launch* (GS_WAIT to GS_RUN on an alarm-1 match); *realign* (GS_RUN to GS_RUN on an alarm-1 match while realignment is allowed); *stop* (GS_WAIT or GS_RUN to GS_IDLE when the start-mode bit is cleared).

Top module: `alarm_pulse_unit`

## Requirements
- R1: After reset, `evt_flags`, `pulse_pin`, `alarm_pin` and `clk_out` are all 0. Both alarms are disarmed, all periods are 0, the prescale value is 1 and the controller is in GS_IDLE.
- R2: The word address map is as follows:
  - 0: control
  - 1: alarm 1 low word
  - 2: alarm 1 high word
  - 3: alarm 2 low word
  - 4: alarm 2 high word
  - 5, 6, 7: periods of generators 1, 2 and 3
  - 8: prescale (bits 15:0)

  Control bits are: 2 timer enable, 14 realign disable, 28 start mode, 30 alarm 2 polarity, 31 alarm 1 polarity. A write takes effect at the clock edge that samples it.
- R3: Writing either word of an alarm arms that alarm. An armed alarm with value A matches when the sampled time T satisfies A <= T < A + tick. The edge that samples the match sets `evt_flags` bit 16 (alarm 1) or bit 17 (alarm 2) for one cycle and disarms the alarm until its next write.
- R4: `alarm_pin[i]` equals the alarm event XOR the polarity bit of that alarm. A polarity bit of 1 gives a pin that idles high and pulses low.
- R5: The generators start only from GS_WAIT, on an alarm-1 match. GS_IDLE never moves directly to GS_RUN.
- R6: After a launch on the sample at time T0, generator k pulses for one cycle on `pulse_pin[k-1]` and on `evt_flags` bit 8-k. It pulses on each enabled sample T for which some n >= 0 gives T <= T0 + tick + n*P < T + tick. This requires P >= tick. A period of 0 keeps that generator silent.
- R7: Clearing the start-mode bit returns the controller to GS_IDLE and stops all pulses.
- R8: An alarm-1 match in GS_RUN restarts the phase of every generator from that sample, as in R6, and gives no pulse on that edge. When realign disable is set, the match leaves the running phase unchanged.
- R9: While the timer enable bit is 0, the generators hold their position and do not pulse, and `clk_out` does not toggle.
- R10: `clk_out` toggles after every N enabled cycles, where N is the prescale value and 0 is treated as 1. A prescale write restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current time in ns from the timer counter |
| tick_ns | input | 10 | Time added per enabled clock, in ns |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| alarm_pin | output | 2 | Alarm outputs with selectable polarity (bit 0 = alarm 1) |
| pulse_pin | output | 3 | Interval pulse outputs (bit 0 = generator 1) |
| clk_out | output | 1 | Prescaled output clock |
| evt_flags | output | 32 | One-cycle event strobes at bits 17, 16, 7, 6, 5 |

## Verification
The hardest situation to reach from the ports is a realignment that lands at an arbitrary phase. Alarm 1 has to be rewritten while the generators run, to a value that is not a multiple of the tick. The generators then have to be watched as they drop the old phase and take up the new one, with the realign-disable bit both set and clear. The directed part of the bench rewrites alarm 1 at deliberately misaligned times during a pulse train. The random part draws tick periods, periods that do not divide by the tick, alarm offsets and mid-run rewrites of alarms and control bits from a seeded generator. A bench function predicts every pulse from the launch time and the period alone.

// File: rtl/apu_pkg.sv
package apu_pkg;
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_ALM_LO = 1;   // alarm i low word at 1 + 2*i
    localparam int ADDR_PER    = 5;   // generator g period at 5 + g
    localparam int ADDR_PRESC  = 8;

    localparam int CB_ENABLE   = 2;
    localparam int CB_NOALIGN  = 14;
    localparam int CB_START    = 28;
    localparam int CB_POL2     = 30;
    localparam int CB_POL1     = 31;

    localparam int EV_ALM1     = 16;
    localparam int EV_ALM2     = 17;
    localparam int EV_GEN1     = 7;   // generator g reports at EV_GEN1 - g

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_WAIT = 2'd1,
        GS_RUN  = 2'd2
    } gen_state_t;
endpackage

// File: rtl/apu_alarm_match.sv
module apu_alarm_match #(
    parameter int TIME_W = 64,
    parameter int TICK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TICK_W-1:0] tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wr_data,
    output logic              hit,
    output logic              evt
);
    localparam int HALF = TIME_W / 2;

    logic [TIME_W-1:0] alarm_q;
    logic              armed_q;
    logic [TIME_W-1:0] delta;

    assign delta = time_now - alarm_q;
    assign hit   = armed_q && (time_now >= alarm_q) &&
                   (delta < {{(TIME_W-TICK_W){1'b0}}, tick});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
            armed_q <= 1'b0;
            evt     <= 1'b0;
        end else begin
            evt <= hit;
            if (wr_lo) alarm_q[HALF-1:0]      <= wr_data[HALF-1:0];
            if (wr_hi) alarm_q[TIME_W-1:HALF] <= wr_data[HALF-1:0];
            if (wr_lo || wr_hi) armed_q <= 1'b1;
            else if (hit)       armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/apu_interval_gen.sv
module apu_interval_gen #(
    parameter int PER_W  = 32,
    parameter int TICK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [TICK_W-1:0] tick,
    input  logic              run,
    input  logic              en,
    input  logic              load,
    output logic              pulse
);
    localparam int CW = PER_W + 1;

    logic [CW-1:0] remain_q;   // distance from the current sample to the next target
    logic [CW-1:0] tick_x;
    logic [CW-1:0] per_x;

    assign tick_x = {{(CW-TICK_W){1'b0}}, tick};
    assign per_x  = {1'b0, period};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            pulse    <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (load) begin
                remain_q <= '0;
            end else if (run && en && (period != '0)) begin
                if (remain_q < tick_x) begin
                    pulse    <= 1'b1;
                    remain_q <= remain_q + per_x - tick_x;
                end else begin
                    remain_q <= remain_q - tick_x;
                end
            end
        end
    end
endmodule

// File: rtl/apu_clk_div.sv
module apu_clk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             clk_out
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? '0 : div - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clk_out <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            if (cnt_q >= last) begin
                cnt_q   <= '0;
                clk_out <= ~clk_out;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/alarm_pulse_unit.sv
module alarm_pulse_unit
    import apu_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int TICK_W = 10,
    parameter int PER_W  = 32,
    parameter int N_GEN  = 3,
    parameter int DIV_W  = 16,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TICK_W-1:0] tick_ns,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [31:0]       wr_data,
    output logic [1:0]        alarm_pin,
    output logic [N_GEN-1:0]  pulse_pin,
    output logic              clk_out,
    output logic [31:0]       evt_flags
);
    localparam int N_ALM = 2;

    logic             en_q, noalign_q, start_q;
    logic [1:0]       pol_q;
    logic [DIV_W-1:0] presc_q;
    logic [PER_W-1:0] period_q [N_GEN];
    logic [N_ALM-1:0] alm_hit, alm_evt;
    logic             gen_run, gen_load, presc_wr;
    gen_state_t       state_q, state_d;

    assign presc_wr = wr_en && (wr_addr == AW'(ADDR_PRESC));

    // control and prescale registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            noalign_q <= 1'b0;
            start_q   <= 1'b0;
            pol_q     <= 2'b00;
            presc_q   <= DIV_W'(1);
        end else begin
            if (wr_en && (wr_addr == AW'(ADDR_CTRL))) begin
                en_q      <= wr_data[CB_ENABLE];
                noalign_q <= wr_data[CB_NOALIGN];
                start_q   <= wr_data[CB_START];
                pol_q     <= {wr_data[CB_POL2], wr_data[CB_POL1]};
            end
            if (presc_wr) presc_q <= wr_data[DIV_W-1:0];
        end
    end

    // alarm comparators
    for (genvar i = 0; i < N_ALM; i++) begin : g_alarm
        apu_alarm_match #(.TIME_W(TIME_W), .TICK_W(TICK_W)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .time_now (time_now),
            .tick     (tick_ns),
            .wr_lo    (wr_en && (wr_addr == AW'(ADDR_ALM_LO + 2*i))),
            .wr_hi    (wr_en && (wr_addr == AW'(ADDR_ALM_LO + 2*i + 1))),
            .wr_data  (wr_data),
            .hit      (alm_hit[i]),
            .evt      (alm_evt[i])
        );
    end

    assign alarm_pin = alm_evt ^ pol_q;

    // generator controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    // generator controller: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: if (start_q) state_d = GS_WAIT;
            GS_WAIT: begin
                if (!start_q)       state_d = GS_IDLE;
                else if (alm_hit[0]) state_d = GS_RUN;
            end
            GS_RUN:  if (!start_q) state_d = GS_IDLE;
            default: state_d = GS_IDLE;
        endcase
    end

    // generator controller: outputs
    always_comb begin
        gen_run  = 1'b0;
        gen_load = 1'b0;
        unique case (state_q)
            GS_IDLE: ;
            GS_WAIT: gen_load = start_q && alm_hit[0];
            GS_RUN: begin
                gen_run  = 1'b1;
                gen_load = start_q && alm_hit[0] && !noalign_q;
            end
            default: ;
        endcase
    end

    // interval generators with their period registers
    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) period_q[g] <= '0;
            else if (wr_en && (wr_addr == AW'(ADDR_PER + g))) period_q[g] <= wr_data[PER_W-1:0];
        end

        apu_interval_gen #(.PER_W(PER_W), .TICK_W(TICK_W)) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .period (period_q[g]),
            .tick   (tick_ns),
            .run    (gen_run),
            .en     (en_q),
            .load   (gen_load),
            .pulse  (pulse_pin[g])
        );
    end

    apu_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .clr     (presc_wr),
        .div     (presc_q),
        .clk_out (clk_out)
    );

    always_comb begin
        evt_flags          = '0;
        evt_flags[EV_ALM1] = alm_evt[0];
        evt_flags[EV_ALM2] = alm_evt[1];
        for (int g = 0; g < N_GEN; g++) evt_flags[EV_GEN1 - g] = pulse_pin[g];
    end
endmodule

// File: rtl/apu_checker.sv
module apu_checker
    import apu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input gen_state_t state,
    input logic       hit1,
    input logic       en,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [2:0] pulse,
    input logic       clk_out,
    input logic [31:0] evt
);
    logic a1_wr;
    assign a1_wr = wr_en && ((wr_addr == 4'd1) || (wr_addr == 4'd2));

    // R3: an alarm-1 event is not repeated unless the alarm was rewritten
    p_alarm_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EV_ALM1] |=> (!evt[EV_ALM1] || $past(a1_wr, 2)));

    // R5: launch only from GS_WAIT on an alarm-1 match
    p_launch_on_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == GS_WAIT && state == GS_RUN) |-> $past(hit1));

    // R5: GS_IDLE never jumps straight to GS_RUN
    p_no_idle_to_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == GS_IDLE) |-> (state != GS_RUN));

    // R6: pulses come only from a running controller
    p_pulse_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |-> ($past(state) == GS_RUN));

    // R9: no pulse after a disabled cycle
    p_pulse_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |-> $past(en));

    // R9: output clock holds while the timer is disabled
    p_clk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> $stable(clk_out));
endmodule

bind alarm_pulse_unit apu_checker i_apu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .hit1    (alm_hit[0]),
    .en      (en_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .pulse   (pulse_pin),
    .clk_out (clk_out),
    .evt     (evt_flags)
);

// File: tb/test_alarm_pulse_unit.sv
module test_alarm_pulse_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic [9:0]  tick_ns = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  alarm_pin;
    logic [2:0]  pulse_pin;
    logic        clk_out;
    logic [31:0] evt_flags;

    alarm_pulse_unit i_alarm_pulse_unit (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .tick_ns(tick_ns),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_pin(alarm_pin), .pulse_pin(pulse_pin), .clk_out(clk_out),
        .evt_flags(evt_flags)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 1'b0;
    string ptag = "R6";
    string ctag = "R10";

    // bench model state
    logic [63:0] T = 64'd1000;
    logic [9:0]  tk = 10'd8;
    logic [31:0] m_ctrl = '0;
    logic [63:0] m_al [2];
    bit          m_arm [2];
    logic [31:0] m_per [3];
    logic [15:0] m_ps = 16'd1;
    logic [15:0] m_pc = '0;
    bit          m_ck = 1'b0;
    int          m_st = 0;   // 0 idle, 1 wait, 2 run
    logic [63:0] m_B = '0;

    localparam logic [31:0] EN  = 32'h0000_0004;
    localparam logic [31:0] NOA = 32'h0000_4000;
    localparam logic [31:0] ST  = 32'h1000_0000;
    localparam logic [31:0] P2  = 32'h4000_0000;
    localparam logic [31:0] P1  = 32'h8000_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at time %0d", tag, act, exp, T);
        end
    endtask

    // a target B + n*P (n >= 0) lies in [t, t + k)
    function automatic bit due(input logic [63:0] t, input logic [63:0] b,
                               input logic [31:0] p, input logic [9:0] k);
        logic [63:0] r;
        if (t <= b) return (b - t) < {54'd0, k};
        r = (t - b) % {32'd0, p};
        if (r == 0) return 1'b1;
        return ({32'd0, p} - r) < {54'd0, k};
    endfunction

    task automatic step(input bit w, input logic [3:0] a, input logic [31:0] d);
        bit          en;
        bit          ld;
        bit   [1:0]  hit;
        logic [2:0]  pp;
        logic [31:0] ev;
        logic [15:0] lim;
        wr_en = w; wr_addr = a; wr_data = d; time_now = T; tick_ns = tk;
        en = m_ctrl[2];
        for (int i = 0; i < 2; i++)
            hit[i] = m_arm[i] && (T >= m_al[i]) && ((T - m_al[i]) < {54'd0, tk});
        ld = m_ctrl[28] && hit[0] && (m_st == 1 || (m_st == 2 && !m_ctrl[14]));
        for (int g = 0; g < 3; g++)
            pp[g] = (m_st == 2) && en && (m_per[g] != 0) && !ld && due(T, m_B, m_per[g], tk);
        ev = '0; ev[16] = hit[0]; ev[17] = hit[1];
        for (int g = 0; g < 3; g++) ev[7-g] = pp[g];
        case (m_st)
            0: if (m_ctrl[28]) m_st = 1;
            1: if (!m_ctrl[28]) m_st = 0; else if (hit[0]) begin m_st = 2; m_B = T + {54'd0, tk}; end
            default: if (!m_ctrl[28]) m_st = 0; else if (ld) m_B = T + {54'd0, tk};
        endcase
        if (w && a == 4'd8) m_pc = '0;
        else if (en) begin
            lim = (m_ps == 0) ? 16'd1 : m_ps;
            if (m_pc >= lim - 16'd1) begin m_pc = '0; m_ck = ~m_ck; end
            else m_pc = m_pc + 16'd1;
        end
        for (int i = 0; i < 2; i++)
            if (w && (a == 4'(1 + 2*i) || a == 4'(2 + 2*i))) m_arm[i] = 1'b1;
            else if (hit[i]) m_arm[i] = 1'b0;
        if (w) begin
            case (a)
                4'd0: m_ctrl = d;
                4'd1: m_al[0][31:0]  = d;
                4'd2: m_al[0][63:32] = d;
                4'd3: m_al[1][31:0]  = d;
                4'd4: m_al[1][63:32] = d;
                4'd5, 4'd6, 4'd7: m_per[a - 4'd5] = d;
                4'd8: m_ps = d[15:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk({ptag, " events"}, evt_flags, ev);
        chk("R4 alarm pin", {30'd0, alarm_pin}, {30'd0, hit[1] ^ m_ctrl[30], hit[0] ^ m_ctrl[31]});
        chk({ptag, " pulse pins"}, {29'd0, pulse_pin}, {29'd0, pp});
        chk({ctag, " clk_out"}, {31'd0, clk_out}, {31'd0, m_ck});
        if (en) T = T + {54'd0, tk};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 32'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 2; i++) begin m_al[i] = '0; m_arm[i] = 1'b0; end
        for (int g = 0; g < 3; g++) m_per[g] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 events", evt_flags, 32'd0);
        chk("R1 pulses", {29'd0, pulse_pin}, 32'd0);
        chk("R1 alarm pins", {30'd0, alarm_pin}, 32'd0);
        chk("R1 clk_out", {31'd0, clk_out}, 32'd0);
        rst_n = 1'b1;
        ptag = "R1"; idle(4);

        // R2/R3/R5/R6: aligned launch, alarm 2 inside its tick window, polarity
        ptag = "R2";
        wr(4'd0, EN | ST | P2);
        wr(4'd5, 32'd80);
        wr(4'd6, 32'd44);
        wr(4'd7, 32'd0);
        wr(4'd1, 32'd1992);
        wr(4'd2, 32'd0);
        wr(4'd3, 32'd2003);
        wr(4'd4, 32'd0);
        ptag = "R6"; idle(150);

        // R8: realign at a misaligned time, then with realign disabled
        ptag = "R8";
        wr(4'd1, T[31:0] + 32'd43);
        idle(60);
        wr(4'd0, EN | ST | NOA | P1);
        wr(4'd1, T[31:0] + 32'd29);
        idle(60);

        // R9: hold while disabled
        ptag = "R9"; ctag = "R9";
        wr(4'd0, ST);
        idle(20);
        wr(4'd0, EN | ST);
        idle(40);
        ctag = "R10";

        // R7: stop, then re-arm waits for alarm 1 (R5)
        ptag = "R7";
        wr(4'd0, EN);
        idle(40);
        ptag = "R5";
        wr(4'd0, EN | ST);
        idle(20);
        wr(4'd1, T[31:0] + 32'd40);
        idle(60);

        // R10: prescale values including 0
        ctag = "R10";
        wr(4'd8, 32'd3);  idle(30);
        wr(4'd8, 32'd0);  idle(12);
        wr(4'd8, 32'd5);  idle(30);

        // random rounds
        ptag = "R6";
        for (int r = 0; r < 30; r++) begin
            logic [31:0] c;
            wr(4'd0, EN);
            idle(2);
            tk = 10'(1 + $urandom % 20);
            for (int g = 0; g < 3; g++)
                wr(4'(5 + g), ($urandom % 8 == 0) ? 32'd0 : {22'd0, tk} + ($urandom % ({22'd0, tk} * 12)));
            wr(4'd1, T[31:0] + {22'd0, tk} * (3 + $urandom % 10) + ($urandom % {22'd0, tk}));
            wr(4'd3, T[31:0] + ($urandom % 200));
            c = EN | ST | ($urandom % 2 ? NOA : 0) | ($urandom % 2 ? P1 : 0) | ($urandom % 2 ? P2 : 0);
            wr(4'd0, c);
            for (int i = 0; i < 100; i++) begin
                int sel;
                sel = $urandom % 40;
                if (sel == 0)      begin ptag = "R8"; wr(4'd1, T[31:0] + ($urandom % 60)); end
                else if (sel == 1) wr(4'd3, T[31:0] + ($urandom % 60));
                else if (sel == 2) wr(4'd0, EN | ST | ($urandom % 2 ? NOA : 0) | ($urandom % 2 ? P1 : 0));
                else if (sel == 3) wr(4'd8, $urandom % 6);
                else               idle(1);
            end
            ptag = "R6";
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule